// File: doc/BRIEF.md
# Predicated Instruction Commit Gate

This block sits at the writeback point of a simple in-order pipeline and decides, one operation per cycle, whether that operation may change architectural state. It holds a file of one-bit guard flags. Every issued operation names one flag as its guard. A true guard lets the operation commit normally. A false guard turns it into a no-op: no register write, no memory request, no flag update, and no exception, even when the operation would have faulted.

Compare operations write a pair of flags in one cycle, the outcome and its inverse. The pipeline uses these flags to if-convert short branches. Two data-dependent forms are also handled. A move-if-zero copies an operand into the destination only when a third operand is zero. A guarded-by-operand load reads memory and writes its destination only when that third operand is non-zero. A prefetch issues a memory request that can never trap. The block's outputs are combinational within the issue cycle. Flag updates are registered, and the very next operation sees them.

Top module: `pred_commit_gate`

## Requirements
- R1: After synchronous reset, every guard flag reads false except flag 0, which reads true. An operation guarded by flag 0 commits, and one guarded by any other flag (for example 5 or 63) is annulled.
- R2: Each operation selects exactly one of the 64 flags through `iss_guard`. When that flag is true the operation commits. When it is false, `wb_we`, `mem_req` and `exc_raise` stay low and no flag changes. This includes an annulled compare.
- R3: An annulled operation never raises `exc_raise`, whatever the value of `iss_fault`.
- R4: A compare (op 2) sets flag `iss_pdst_t` to its outcome and flag `iss_pdst_f` to the inverse, in the same cycle. The test is chosen by `iss_cmp_kind`: 0 means A equals B, 1 means A differs from B, 2 means A is less than B as signed values, and 3 means A is less than B as unsigned values.
- R5: Flag 0 ignores writes and stays true. When a compare names the same flag for both targets, that flag takes the outcome, not the inverse.
- R6: A flag written by a compare governs an operation issued in the very next cycle, with no stall.
- R7: A move-if-zero (op 3) writes `opnd_b` to `iss_dst` when `opnd_c` is zero. Otherwise `wb_we` stays low.
- R8: A conditional load (op 4) with non-zero `opnd_c` asserts `mem_req` at address `opnd_a` and writes `ld_data` to `iss_dst`. With zero `opnd_c` there is no request, no write and no exception.
- R9: A prefetch (op 6) asserts `mem_req` at `opnd_a` and never writes a register or raises `exc_raise`, even with `iss_fault` high.
- R10: A committed operation with `iss_fault` high raises `exc_raise`. This applies to ALU (op 1), compare, move-if-zero, plain load, and conditional load with non-zero `opnd_c`. The fault suppresses its register write, its memory request and its flag update.
- R11: An ALU operation (op 1) writes `alu_res`. A plain load (op 5) requests `opnd_a` and writes `ld_data`. Op 0 and op 7 have no effect, and no effect occurs while `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is present this cycle |
| iss_op | input | 3 | Operation class |
| iss_guard | input | PW (6) | Index of the guarding flag |
| iss_dst | input | RW (5) | Destination register index |
| iss_pdst_t | input | PW (6) | Flag receiving the compare outcome |
| iss_pdst_f | input | PW (6) | Flag receiving the inverted outcome |
| iss_cmp_kind | input | 2 | Compare test select |
| iss_fault | input | 1 | Operation would trap if committed |
| opnd_a | input | XLEN (32) | First operand / memory address |
| opnd_b | input | XLEN (32) | Second operand / move source |
| opnd_c | input | XLEN (32) | Zero-test operand |
| alu_res | input | XLEN (32) | Result from the execute stage |
| ld_data | input | XLEN (32) | Data returned for a load |
| wb_we | output | 1 | Register write enable |
| wb_addr | output | RW (5) | Register write index |
| wb_data | output | XLEN (32) | Register write data |
| mem_req | output | 1 | Memory request enable |
| mem_addr | output | XLEN (32) | Memory request address |
| exc_raise | output | 1 | Exception taken by this operation |

## Verification
The bench builds the block with its defaults: 64 flags, 32 registers and 32-bit data. This places the highest guard index, 63, and the compare targets at both ends of the flag file within reach. The 32-bit width lets the signed and unsigned compare tests disagree on the same operand pair, such as all ones against one. Flag updates are traced through back-to-back dependent operations. Faults are injected on committed, annulled, operand-suppressed and prefetch operations.

// File: rtl/pred_commit_gate.sv
module pred_commit_gate #(
  parameter int XLEN  = 32,
  parameter int NPRED = 64,
  parameter int NREG  = 32,
  localparam int PW = $clog2(NPRED),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [2:0]      iss_op,
  input  logic [PW-1:0]   iss_guard,
  input  logic [RW-1:0]   iss_dst,
  input  logic [PW-1:0]   iss_pdst_t,
  input  logic [PW-1:0]   iss_pdst_f,
  input  logic [1:0]      iss_cmp_kind,
  input  logic            iss_fault,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] opnd_c,
  input  logic [XLEN-1:0] alu_res,
  input  logic [XLEN-1:0] ld_data,
  output logic            wb_we,
  output logic [RW-1:0]   wb_addr,
  output logic [XLEN-1:0] wb_data,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic            exc_raise
);

  localparam logic [2:0] OP_ALU   = 3'd1;
  localparam logic [2:0] OP_CMP   = 3'd2;
  localparam logic [2:0] OP_CMOVZ = 3'd3;
  localparam logic [2:0] OP_LDC   = 3'd4;
  localparam logic [2:0] OP_LD    = 3'd5;
  localparam logic [2:0] OP_PREF  = 3'd6;

  logic [NPRED-1:0] pred_q;

  wire is_alu   = iss_op == OP_ALU;
  wire is_cmp   = iss_op == OP_CMP;
  wire is_cmovz = iss_op == OP_CMOVZ;
  wire is_ldc   = iss_op == OP_LDC;
  wire is_ld    = iss_op == OP_LD;
  wire is_pref  = iss_op == OP_PREF;

  wire c_zero   = opnd_c == '0;
  wire ldc_live = is_ldc & ~c_zero;

  wire guard_ok  = iss_valid & pred_q[iss_guard];
  wire can_fault = is_alu | is_cmp | is_cmovz | is_ld | ldc_live;

  assign exc_raise = guard_ok & iss_fault & can_fault;

  wire commit = guard_ok & ~exc_raise;

  logic cmp_out;
  always_comb begin
    case (iss_cmp_kind)
      2'd0:    cmp_out = opnd_a == opnd_b;
      2'd1:    cmp_out = opnd_a != opnd_b;
      2'd2:    cmp_out = $signed(opnd_a) < $signed(opnd_b);
      default: cmp_out = opnd_a < opnd_b;
    endcase
  end

  assign wb_we   = commit & (is_alu | is_ld | ldc_live | (is_cmovz & c_zero));
  assign wb_addr = iss_dst;
  assign wb_data = is_alu ? alu_res : (is_cmovz ? opnd_b : ld_data);

  assign mem_req  = commit & (is_ld | is_pref | ldc_live);
  assign mem_addr = opnd_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q <= NPRED'(1);
    end else if (commit & is_cmp) begin
      if (iss_pdst_f != '0) pred_q[iss_pdst_f] <= ~cmp_out;
      if (iss_pdst_t != '0) pred_q[iss_pdst_t] <= cmp_out;
    end
  end

endmodule

// File: rtl/pred_commit_gate_sva.sv
module pred_commit_gate_sva #(
  parameter int XLEN  = 32,
  parameter int NPRED = 64,
  parameter int PW    = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            iss_valid,
  input logic [2:0]      iss_op,
  input logic [PW-1:0]   iss_guard,
  input logic [PW-1:0]   iss_pdst_t,
  input logic [PW-1:0]   iss_pdst_f,
  input logic [XLEN-1:0] opnd_c,
  input logic            wb_we,
  input logic            mem_req,
  input logic            exc_raise,
  input logic [NPRED-1:0] pred_q
);

  wire cmp_done = iss_valid && iss_op == 3'd2 && pred_q[iss_guard] && !exc_raise;

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> !wb_we && !mem_req && !exc_raise);

  a_r3_annul_silent: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !pred_q[iss_guard]) |-> !exc_raise && !wb_we && !mem_req);

  a_r5_flag0_true: assert property (@(posedge clk) disable iff (rst)
    pred_q[0]);

  a_r4_pair_inverse: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmp_done && iss_pdst_t != iss_pdst_f &&
                          iss_pdst_t != '0 && iss_pdst_f != '0))
    |-> pred_q[$past(iss_pdst_t)] != pred_q[$past(iss_pdst_f)]);

  a_r2_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmp_done)) |-> $stable(pred_q));

  a_r9_prefetch_safe: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_op == 3'd6) |-> !exc_raise && !wb_we);

  a_r8_zero_operand_load: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_op == 3'd4 && opnd_c == '0) |-> !mem_req && !wb_we && !exc_raise);

  a_r10_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    exc_raise |-> !wb_we && !mem_req);

endmodule

bind pred_commit_gate pred_commit_gate_sva #(.XLEN(XLEN), .NPRED(NPRED), .PW(PW)) u_sva (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
  .iss_guard(iss_guard), .iss_pdst_t(iss_pdst_t), .iss_pdst_f(iss_pdst_f),
  .opnd_c(opnd_c), .wb_we(wb_we), .mem_req(mem_req),
  .exc_raise(exc_raise), .pred_q(pred_q)
);

// File: tb/tb_pred_commit_gate.sv
module tb_pred_commit_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [2:0] iss_op = '0;
  logic [5:0] iss_guard = '0, iss_pdst_t = '0, iss_pdst_f = '0;
  logic [4:0] iss_dst = '0;
  logic [1:0] iss_cmp_kind = '0;
  logic iss_fault = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, alu_res = '0, ld_data = '0;
  logic wb_we, mem_req, exc_raise;
  logic [4:0] wb_addr;
  logic [31:0] wb_data, mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_commit_gate dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_guard(iss_guard), .iss_dst(iss_dst), .iss_pdst_t(iss_pdst_t),
    .iss_pdst_f(iss_pdst_f), .iss_cmp_kind(iss_cmp_kind), .iss_fault(iss_fault),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .alu_res(alu_res),
    .ld_data(ld_data), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .exc_raise(exc_raise)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mr;
    logic [31:0] ma;
    logic        ex;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit pm[64];

  task automatic issue(input string tag, input logic [2:0] op, input int g,
                       input logic [4:0] d, input int pt, input int pf,
                       input logic [1:0] kind, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c,
                       input logic [31:0] res, input logic [31:0] ld,
                       input logic flt);
    exp_t e;
    bit gt, cz, fl, ex, go, co;
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_guard = 6'(g); iss_dst = d;
    iss_pdst_t = 6'(pt); iss_pdst_f = 6'(pf); iss_cmp_kind = kind;
    opnd_a = a; opnd_b = b; opnd_c = c; alu_res = res; ld_data = ld; iss_fault = flt;
    gt = pm[g];
    cz = (c == 0);
    fl = (op == 1) || (op == 2) || (op == 3) || (op == 5) || (op == 4 && !cz);
    ex = gt && flt && fl;
    go = gt && !ex;
    case (kind)
      2'd0: co = (a == b);
      2'd1: co = (a != b);
      2'd2: co = ($signed(a) < $signed(b));
      default: co = (a < b);
    endcase
    e = '0;
    e.ex = ex;
    e.we = go && (op == 1 || op == 5 || (op == 4 && !cz) || (op == 3 && cz));
    e.wa = d;
    e.wd = (op == 1) ? res : (op == 3) ? b : ld;
    e.mr = go && (op == 5 || op == 6 || (op == 4 && !cz));
    e.ma = a;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    if (go && op == 2) begin
      if (pf != 0) pm[pf] = !co;
      if (pt != 0) pm[pt] = co;
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    iss_valid = 1'b0; iss_fault = 1'b1; iss_op = 3'd5; opnd_c = 32'd1;
    q_exp.push_back('0);
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q_exp.size() > 0) begin
        exp_t e;
        string t;
        bit bad;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        bad = (wb_we !== e.we) || (mem_req !== e.mr) || (exc_raise !== e.ex) ||
              (e.we && (wb_addr !== e.wa || wb_data !== e.wd)) ||
              (e.mr && mem_addr !== e.ma);
        n_checks++;
        if (bad) begin
          n_fail++;
          $display("FAIL %s: we=%0b wa=%0d wd=%h req=%0b ma=%h exc=%0b expected we=%0b wa=%0d wd=%h req=%0b ma=%h exc=%0b",
                   t, wb_we, wb_addr, wb_data, mem_req, mem_addr, exc_raise,
                   e.we, e.wa, e.wd, e.mr, e.ma, e.ex);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    foreach (pm[i]) pm[i] = 0;
    pm[0] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    issue("R1 flag0 true", 3'd1, 0, 5'd3, 0, 0, 2'd0, 0, 0, 0, 32'hA5A5_0001, 0, 0);
    issue("R1 flag5 false", 3'd1, 5, 5'd4, 0, 0, 2'd0, 0, 0, 0, 32'h1234, 0, 0);
    issue("R1 flag63 false", 3'd1, 63, 5'd4, 0, 0, 2'd0, 0, 0, 0, 32'h1234, 0, 0);
    idle("R11 idle with fault");
    // R4 R6 compare and next-cycle use
    issue("R4 cmp eq", 3'd2, 0, 5'd0, 5, 6, 2'd0, 32'd5, 32'd5, 0, 0, 0, 0);
    issue("R6 use p5 next cycle", 3'd1, 5, 5'd7, 0, 0, 2'd0, 0, 0, 0, 32'hBEEF, 0, 0);
    issue("R4 p6 inverse", 3'd1, 6, 5'd7, 0, 0, 2'd0, 0, 0, 0, 32'hBEEF, 0, 0);
    issue("R4 cmp ne false", 3'd2, 0, 5'd0, 5, 6, 2'd1, 32'd9, 32'd9, 0, 0, 0, 0);
    issue("R6 p5 now false", 3'd1, 5, 5'd8, 0, 0, 2'd0, 0, 0, 0, 32'h11, 0, 0);
    issue("R4 p6 now true", 3'd1, 6, 5'd8, 0, 0, 2'd0, 0, 0, 0, 32'h22, 0, 0);
    issue("R4 cmp lt signed", 3'd2, 0, 5'd0, 63, 62, 2'd2, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0);
    issue("R4 p63 signed true", 3'd1, 63, 5'd9, 0, 0, 2'd0, 0, 0, 0, 32'h33, 0, 0);
    issue("R4 p62 signed inv", 3'd1, 62, 5'd9, 0, 0, 2'd0, 0, 0, 0, 32'h33, 0, 0);
    issue("R4 cmp lt unsigned", 3'd2, 0, 5'd0, 63, 62, 2'd3, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0);
    issue("R4 p63 unsigned false", 3'd1, 63, 5'd9, 0, 0, 2'd0, 0, 0, 0, 32'h44, 0, 0);
    issue("R4 p62 unsigned inv", 3'd1, 62, 5'd9, 0, 0, 2'd0, 0, 0, 0, 32'h44, 0, 0);
    // R5 flag0 and same-target
    issue("R5 cmp false into p0", 3'd2, 0, 5'd0, 0, 7, 2'd0, 32'd1, 32'd2, 0, 0, 0, 0);
    issue("R5 p0 still true", 3'd1, 0, 5'd10, 0, 0, 2'd0, 0, 0, 0, 32'h55, 0, 0);
    issue("R5 p7 got inverse", 3'd1, 7, 5'd10, 0, 0, 2'd0, 0, 0, 0, 32'h56, 0, 0);
    issue("R5 same target", 3'd2, 0, 5'd0, 8, 8, 2'd0, 32'd4, 32'd4, 0, 0, 0, 0);
    issue("R5 p8 takes outcome", 3'd1, 8, 5'd11, 0, 0, 2'd0, 0, 0, 0, 32'h66, 0, 0);
    // R2 annulled compare
    issue("R2 annulled cmp", 3'd2, 9, 5'd0, 10, 11, 2'd0, 32'd1, 32'd1, 0, 0, 0, 0);
    issue("R2 p10 unchanged", 3'd1, 10, 5'd12, 0, 0, 2'd0, 0, 0, 0, 32'h77, 0, 0);
    issue("R2 p11 unchanged", 3'd1, 11, 5'd12, 0, 0, 2'd0, 0, 0, 0, 32'h78, 0, 0);
    // R7 move-if-zero
    issue("R7 cmovz zero", 3'd3, 0, 5'd13, 0, 0, 2'd0, 0, 32'hCAFE_F00D, 0, 32'h1, 0, 0);
    issue("R7 cmovz nonzero", 3'd3, 0, 5'd13, 0, 0, 2'd0, 0, 32'hCAFE_F00D, 32'd3, 32'h1, 0, 0);
    issue("R7 cmovz annulled", 3'd3, 5, 5'd13, 0, 0, 2'd0, 0, 32'hCAFE_F00D, 0, 32'h1, 0, 0);
    // R8 conditional load
    issue("R8 ldc nonzero", 3'd4, 0, 5'd14, 0, 0, 2'd0, 32'h0000_1000, 0, 32'd1, 0, 32'hD00D_0001, 0);
    issue("R8 ldc zero", 3'd4, 0, 5'd14, 0, 0, 2'd0, 32'h0000_1000, 0, 0, 0, 32'hD00D_0002, 0);
    issue("R8 ldc zero fault", 3'd4, 0, 5'd14, 0, 0, 2'd0, 32'hDEAD_0000, 0, 0, 0, 32'hD00D_0003, 1);
    // R9 prefetch
    issue("R9 prefetch", 3'd6, 0, 5'd15, 0, 0, 2'd0, 32'h0000_2000, 0, 0, 0, 0, 0);
    issue("R9 prefetch fault", 3'd6, 0, 5'd15, 0, 0, 2'd0, 32'hDEAD_0004, 0, 0, 0, 0, 1);
    // R10 committed faults
    issue("R10 alu fault", 3'd1, 0, 5'd16, 0, 0, 2'd0, 0, 0, 0, 32'h99, 0, 1);
    issue("R10 load fault", 3'd5, 0, 5'd16, 0, 0, 2'd0, 32'hDEAD_0008, 0, 0, 0, 32'h1, 1);
    issue("R10 ldc fault", 3'd4, 6, 5'd16, 0, 0, 2'd0, 32'hDEAD_000C, 0, 32'd2, 0, 32'h1, 1);
    issue("R10 cmp fault", 3'd2, 0, 5'd0, 12, 13, 2'd0, 32'd3, 32'd3, 0, 0, 0, 1);
    issue("R10 p12 not written", 3'd1, 12, 5'd17, 0, 0, 2'd0, 0, 0, 0, 32'hAA, 0, 0);
    issue("R10 p13 not written", 3'd1, 13, 5'd17, 0, 0, 2'd0, 0, 0, 0, 32'hAB, 0, 0);
    // R3 annulled faults
    issue("R3 annulled alu fault", 3'd1, 5, 5'd18, 0, 0, 2'd0, 0, 0, 0, 32'hBB, 0, 1);
    issue("R3 annulled load fault", 3'd5, 63, 5'd18, 0, 0, 2'd0, 32'hDEAD_0010, 0, 0, 0, 32'h2, 1);
    // R11 plain forms
    issue("R11 plain load", 3'd5, 8, 5'd19, 0, 0, 2'd0, 32'h0000_3000, 0, 0, 0, 32'h1357_9BDF, 0);
    issue("R11 nop fault", 3'd0, 0, 5'd19, 0, 0, 2'd0, 0, 0, 0, 32'h1, 32'h1, 1);
    issue("R11 op7", 3'd7, 0, 5'd19, 0, 0, 2'd0, 0, 0, 0, 32'h1, 32'h1, 1);
    idle("R11 idle end");
    @(negedge clk);
    iss_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule